// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This engine stores an incoming frame, delivered one byte at a time, into memory buffers. A ring of descriptors in memory describes those buffers. The ring holds a power-of-two number of descriptors, each eight bytes long. A descriptor carries an ownership flag, packet-boundary and error flags, a 24-bit buffer address and a buffer length held as a negative count. A frame that does not fit one buffer continues in the next owned descriptor. When the frame ends, or when it cannot continue, the engine writes back the byte count and the flags, hands ownership of the last descriptor back, and pulses an event.

Software places the ring base and a length code on the configuration pins and strobes `init`. It then gives descriptors to the engine by setting their ownership flag. Bytes arrive on a valid/ready stream. `in_ready` is combinational from engine state and never depends on `in_valid`. A byte moves on a clock edge where both are high. The engine holds `in_ready` low while it reads or writes a descriptor, and while a byte waits for a fresh buffer. A frame that is dropped is still consumed to its last byte.

Top module: `rxr_scatter`

## Requirements
- R1: An `init` pulse latches `ring_base` and the ring size and returns `cur_idx` to 0 on the next cycle. The ring size is 2 to the power (`ring_len_code` >> 3), limited to 2^MAX_LOG2.
- R2: While `rx_en` is low, a frame arriving at idle is consumed in full, with no memory write and no event.
- R3: If the current descriptor's OWN bit (bit 15 of word 1) is clear at frame start, `miss_evt` pulses for one cycle. The frame is consumed, no memory is written and `cur_idx` does not change.
- R4: Descriptor d lies at byte address base + 8*d, as four little-endian 16-bit words. Word 0 holds address bits 15:0. Word 1 holds the flags in bits 15:8 and address bits 23:16 in bits 7:0. Word 2 holds the negative length. Word 3 holds the byte count. Frame bytes go to consecutive byte addresses. An even address uses the low lane (`mem_be`=01) and an odd address uses the high lane (10).
- R5: A buffer counts as full only when another byte arrives after its negative length has reached zero. The engine then reads the next descriptor's word 1 before it accepts that byte.
- R6: When a full buffer is followed by an owned descriptor, the full buffer's word 3 receives its count. STP (bit 9) is set if it was the frame's first descriptor, OWN stays set, and storing continues in the next descriptor.
- R7: At the last byte, word 3 receives the current buffer's count. ENP (bit 8) is set, STP is set if this is the first descriptor, and OWN is cleared. `rint_evt` pulses and `cur_idx` advances by one.
- R8: When a full buffer is followed by a descriptor without OWN, the full buffer's word 3 receives its count. BUFF (bit 13) and OFLO (bit 12) are set, STP is set if first, and OWN is cleared. `rint_evt` pulses, `cur_idx` moves to the next descriptor and the rest of the frame is dropped.
- R9: The descriptor index wraps to 0 after the last descriptor of the ring.
- R10: `in_ready` is low at reset and in every cycle with a descriptor read or write. Read data returns one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Latch ring configuration, reset index |
| ring_base | input | AW | Ring byte address, 8-byte aligned |
| ring_len_code | input | 8 | Ring size code, log2 size in bits 7:3 |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the frame's final byte |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW-1 | Memory 16-bit word address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Byte lane enables for writes |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| miss_evt | output | 1 | One-cycle missed-frame event |
| rint_evt | output | 1 | One-cycle receive-complete event |
| cur_idx | output | MAX_LOG2 | Current descriptor index |

## Verification
Every memory write is due in the cycle in which `mem_wr` is high. The bench checks the written lane against its precomputed image at that same clock edge. `miss_evt` comes two cycles after the descriptor read is issued. `rint_evt` comes one cycle after the flag write-back, which takes at least three cycles after the last byte. The bench therefore counts events continuously and compares the counts, the index and the whole memory image only after a settle window of twenty idle cycles. Back-pressure is observed as cycles in which a presented byte sees `in_ready` low.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FL_OWN  = 15;
  localparam int FL_BUFF = 13;
  localparam int FL_OFLO = 12;
  localparam int FL_STP  = 9;
  localparam int FL_ENP  = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DROP, ST_FRD, ST_FWT, ST_DATA,
    ST_NRD, ST_NWT, ST_WB3, ST_WB1
  } rxr_st_e;

  typedef enum logic [1:0] {WB_MID, WB_END, WB_OVF} rxr_wb_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW = 24,
  parameter int MAX_LOG2 = 7,
  localparam int IDX_W = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [AW-1:0]    base_in,
  input  logic [7:0]       len_code,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] nidx,
  output logic [AW-1:0]    base,
  output logic [IDX_W-1:0] mask
);
  logic [4:0]       req_lg;
  logic [4:0]       use_lg;
  logic [IDX_W-1:0] mask_n;

  assign req_lg = len_code[7:3];
  assign use_lg = (req_lg > 5'(MAX_LOG2)) ? 5'(MAX_LOG2) : req_lg;

  for (genvar g = 0; g < IDX_W; g++) begin : g_mask
    assign mask_n[g] = (use_lg > 5'(g));
  end

  assign nidx = (idx + 1'b1) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      mask <= '0;
      idx  <= '0;
    end else if (init) begin
      base <= base_in;
      mask <= mask_n;
      idx  <= '0;
    end else if (adv) begin
      idx  <= nidx;
    end
  end
endmodule

// File: rtl/rxr_buf_cursor.sv
module rxr_buf_cursor #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [15:0]   load_neg,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [15:0]   cnt,
  output logic          full
);
  logic [15:0] neg;

  assign full = (neg == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      neg  <= '0;
      cnt  <= '0;
    end else if (load) begin
      addr <= load_addr;
      neg  <= load_neg;
      cnt  <= '0;
    end else if (step) begin
      addr <= addr + 1'b1;
      neg  <= neg + 16'd1;
      cnt  <= cnt + 16'd1;
    end
  end
endmodule

// File: rtl/rxr_scatter.sv
module rxr_scatter
  import rxr_pkg::*;
#(
  parameter int AW = 24,
  parameter int MAX_LOG2 = 7,
  localparam int IDX_W = MAX_LOG2,
  localparam int MW = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [AW-1:0]    ring_base,
  input  logic [7:0]       ring_len_code,
  input  logic             rx_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [MW-1:0]    mem_addr,
  output logic [15:0]      mem_wdata,
  output logic [1:0]       mem_be,
  input  logic [15:0]      mem_rdata,
  output logic             miss_evt,
  output logic             rint_evt,
  output logic [IDX_W-1:0] cur_idx
);
  rxr_st_e          st;
  rxr_wb_e          wbm;
  logic [1:0]       k;
  logic             first;
  logic [7:0]       fl;
  logic [7:0]       hi;
  logic [15:0]      lo;

  logic [IDX_W-1:0] nidx;
  logic [IDX_W-1:0] ring_mask;
  logic [AW-1:0]    rbase;
  logic             adv;

  logic [AW-1:0]    cur_addr;
  logic [15:0]      cur_cnt;
  logic             cur_full;
  logic             load;
  logic             step;

  logic [IDX_W-1:0] dsel;
  logic [1:0]       woff;
  logic [AW-1:0]    daddr;
  logic [7:0]       nfl;
  logic             byte_wr;

  rxr_ring_ptr #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_ptr (
    .clk(clk), .rst_n(rst_n), .init(init), .base_in(ring_base),
    .len_code(ring_len_code), .adv(adv), .idx(cur_idx), .nidx(nidx),
    .base(rbase), .mask(ring_mask)
  );

  rxr_buf_cursor #(.AW(AW)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(AW'({hi, lo})),
    .load_neg(mem_rdata), .step(step), .addr(cur_addr), .cnt(cur_cnt),
    .full(cur_full)
  );

  assign dsel    = (st == ST_NRD) ? nidx : cur_idx;
  assign daddr   = rbase + AW'({dsel, 3'b000});
  assign byte_wr = (st == ST_DATA) && in_valid && !cur_full;
  assign step    = byte_wr;
  assign load    = (st == ST_FWT) && (k == 2'd2);
  assign adv     = (st == ST_WB1);

  always_comb begin
    nfl = fl;
    if (first) nfl[FL_STP-8] = 1'b1;
    case (wbm)
      WB_END: begin
        nfl[FL_ENP-8] = 1'b1;
        nfl[FL_OWN-8] = 1'b0;
      end
      WB_OVF: begin
        nfl[FL_BUFF-8] = 1'b1;
        nfl[FL_OFLO-8] = 1'b1;
        nfl[FL_OWN-8]  = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    in_ready  = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_be    = 2'b11;
    mem_wdata = '0;
    woff      = 2'd1;
    case (st)
      ST_FRD:  begin mem_rd = 1'b1; woff = k; end
      ST_NRD:  mem_rd = 1'b1;
      ST_DATA: begin
        in_ready  = !cur_full;
        mem_wr    = byte_wr;
        mem_be    = cur_addr[0] ? 2'b10 : 2'b01;
        mem_wdata = {in_data, in_data};
      end
      ST_DROP: in_ready = 1'b1;
      ST_WB3:  begin mem_wr = 1'b1; woff = 2'd3; mem_wdata = cur_cnt; end
      ST_WB1:  begin mem_wr = 1'b1; mem_wdata = {nfl, hi}; end
      default: ;
    endcase
    if (st == ST_DATA) mem_addr = cur_addr[AW-1:1];
    else               mem_addr = daddr[AW-1:1] + MW'(woff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wbm      <= WB_END;
      k        <= 2'd1;
      first    <= 1'b0;
      fl       <= '0;
      hi       <= '0;
      lo       <= '0;
      miss_evt <= 1'b0;
      rint_evt <= 1'b0;
    end else begin
      miss_evt <= 1'b0;
      rint_evt <= 1'b0;
      case (st)
        ST_IDLE: if (in_valid) begin
          if (!rx_en) st <= ST_DROP;
          else begin
            st    <= ST_FRD;
            k     <= 2'd1;
            first <= 1'b1;
          end
        end
        ST_FRD: st <= ST_FWT;
        ST_FWT: begin
          case (k)
            2'd1: begin
              fl <= mem_rdata[15:8];
              hi <= mem_rdata[7:0];
              if (first && !mem_rdata[FL_OWN]) begin
                miss_evt <= 1'b1;
                st       <= ST_DROP;
              end else begin
                k  <= 2'd0;
                st <= ST_FRD;
              end
            end
            2'd0: begin
              lo <= mem_rdata;
              k  <= 2'd2;
              st <= ST_FRD;
            end
            default: st <= ST_DATA;
          endcase
        end
        ST_DATA: if (in_valid) begin
          if (cur_full) st <= ST_NRD;
          else if (in_last) begin
            wbm <= WB_END;
            st  <= ST_WB3;
          end
        end
        ST_NRD: st <= ST_NWT;
        ST_NWT: begin
          wbm <= mem_rdata[FL_OWN] ? WB_MID : WB_OVF;
          st  <= ST_WB3;
        end
        ST_WB3: st <= ST_WB1;
        ST_WB1: begin
          case (wbm)
            WB_MID: begin
              first <= 1'b0;
              k     <= 2'd1;
              st    <= ST_FRD;
            end
            WB_END: begin
              rint_evt <= 1'b1;
              st       <= ST_IDLE;
            end
            default: begin
              rint_evt <= 1'b1;
              st       <= ST_DROP;
            end
          endcase
        end
        ST_DROP: if (in_valid && in_last) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_scatter_chk.sv
module rxr_scatter_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             in_ready,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [1:0]       mem_be,
  input logic             miss_evt,
  input logic             rint_evt,
  input logic [IDX_W-1:0] cur_idx,
  input logic [IDX_W-1:0] ring_mask
);
  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_stall_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !in_ready);
  assert_idx_in_ring_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx & ~ring_mask) == '0);
  assert_init_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (cur_idx == '0));
  assert_miss_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> !miss_evt);
  assert_events_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_evt && rint_evt));
  assert_wr_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) != 0));
endmodule

bind rxr_scatter rxr_scatter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .in_ready(in_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be), .miss_evt(miss_evt),
  .rint_evt(rint_evt), .cur_idx(cur_idx), .ring_mask(ring_mask)
);

// File: tb/rxr_scatter_tb.sv
`timescale 1ns/1ps
module rxr_scatter_tb;
  localparam int RB = 'h100;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        init = 0;
  logic [23:0] ring_base = 0;
  logic [7:0]  ring_len_code = 0;
  logic        rx_en = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_data = 0;
  logic        in_last = 0;
  logic        mem_rd, mem_wr;
  logic [22:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata;
  logic        miss_evt, rint_evt;
  logic [6:0]  cur_idx;

  logic [15:0] mem [0:4095];
  logic [15:0] exp_mem [0:4095];
  logic        tb_we = 0;
  logic [11:0] tb_wa = 0;
  logic [15:0] tb_wd = 0;

  int n_chk = 0, n_fail = 0, wr_chk = 0, wr_fail = 0;
  int obs_miss = 0, obs_rint = 0, exp_miss = 0, exp_rint = 0;
  int m_idx = 0, m_mask = 0, stalls = 0;
  bit m_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxr_scatter u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .ring_base(ring_base),
    .ring_len_code(ring_len_code), .rx_en(rx_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .miss_evt(miss_evt), .rint_evt(rint_evt), .cur_idx(cur_idx)
  );

  // memory model; every write is compared with the precomputed image at its edge
  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) begin
      if (mem_be[0]) begin
        mem[mem_addr[11:0]][7:0] <= mem_wdata[7:0];
        wr_chk++;
        if (mem_wdata[7:0] !== exp_mem[mem_addr[11:0]][7:0]) begin
          wr_fail++;
          $display("FAIL R4/R6/R7/R8 write lo @%0h act=%0h exp=%0h", mem_addr[11:0],
                   mem_wdata[7:0], exp_mem[mem_addr[11:0]][7:0]);
        end
      end
      if (mem_be[1]) begin
        mem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
        wr_chk++;
        if (mem_wdata[15:8] !== exp_mem[mem_addr[11:0]][15:8]) begin
          wr_fail++;
          $display("FAIL R4/R6/R7/R8 write hi @%0h act=%0h exp=%0h", mem_addr[11:0],
                   mem_wdata[15:8], exp_mem[mem_addr[11:0]][15:8]);
        end
      end
    end
    if (miss_evt) obs_miss++;
    if (rint_evt) obs_rint++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int wa, input logic [15:0] wd);
    exp_mem[wa] = wd;
    @(negedge clk); tb_we = 1; tb_wa = 12'(wa); tb_wd = wd;
    @(negedge clk); tb_we = 0;
  endtask

  function automatic int dw(input int d);
    return (RB >> 1) + d * 4;
  endfunction

  task automatic set_desc(input int d, input int addr, input int len, input bit own);
    poke(dw(d),     16'(addr));
    poke(dw(d) + 1, {own, 7'b0, 8'(addr >> 16)});
    poke(dw(d) + 2, 16'(-len));
    poke(dw(d) + 3, 16'h0);
  endtask

  task automatic ring_init(input logic [7:0] code, input int mask);
    @(negedge clk); init = 1; ring_base = 24'(RB); ring_len_code = code;
    @(negedge clk); init = 0;
    m_idx = 0; m_mask = mask;
    chk(cur_idx == 0, "R1 index after init", cur_idx, 0);
  endtask

  // behavioural model: fills exp_mem and expected event counts before the frame is sent
  task automatic model_frame(input int n, input int seed);
    int d, nd, cnt;
    bit stp;
    logic [15:0] nl;
    logic [23:0] a;
    logic [7:0]  b;
    if (!m_en) return;
    d = m_idx;
    if (!exp_mem[dw(d) + 1][15]) begin exp_miss++; return; end
    stp = 1; cnt = 0;
    nl = exp_mem[dw(d) + 2];
    a = {exp_mem[dw(d) + 1][7:0], exp_mem[dw(d)]};
    for (int i = 0; i < n; i++) begin
      if (nl == 0) begin
        nd = (d + 1) & m_mask;
        exp_mem[dw(d) + 3] = 16'(cnt);
        if (stp) exp_mem[dw(d) + 1][9] = 1'b1;
        if (exp_mem[dw(nd) + 1][15]) begin
          stp = 0; d = nd; cnt = 0;
          nl = exp_mem[dw(d) + 2];
          a = {exp_mem[dw(d) + 1][7:0], exp_mem[dw(d)]};
        end else begin
          exp_mem[dw(d) + 1][13] = 1'b1;
          exp_mem[dw(d) + 1][12] = 1'b1;
          exp_mem[dw(d) + 1][15] = 1'b0;
          exp_rint++; m_idx = nd;
          return;
        end
      end
      b = 8'((seed + i * 7) & 255);
      if (a[0]) exp_mem[a[12:1]][15:8] = b;
      else      exp_mem[a[12:1]][7:0]  = b;
      a++; nl++; cnt++;
    end
    exp_mem[dw(d) + 3] = 16'(cnt);
    exp_mem[dw(d) + 1][8] = 1'b1;
    if (stp) exp_mem[dw(d) + 1][9] = 1'b1;
    exp_mem[dw(d) + 1][15] = 1'b0;
    exp_rint++; m_idx = (d + 1) & m_mask;
  endtask

  task automatic send_frame(input int n, input int seed);
    model_frame(n, seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'((seed + i * 7) & 255); in_last = (i == n - 1);
      #1;
      while (!in_ready) begin stalls++; @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic check_after(input string tag);
    int bad;
    bad = -1;
    chk(obs_rint == exp_rint, {tag, " R7/R8 rint count"}, obs_rint, exp_rint);
    chk(obs_miss == exp_miss, {tag, " R3 miss count"}, obs_miss, exp_miss);
    chk(cur_idx == 7'(m_idx), {tag, " R9 index"}, cur_idx, m_idx);
    for (int w = 0; w < 4096; w++)
      if (bad < 0 && mem[w] !== exp_mem[w]) bad = w;
    chk(bad < 0, {tag, " R2/R4 memory image"}, bad, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 0 && mem_rd == 0 && mem_wr == 0, "R10 reset handshake", in_ready, 0);
    chk(miss_evt == 0 && rint_evt == 0 && cur_idx == 0, "R1 reset state", cur_idx, 0);
    rst_n = 1;
    ring_init(8'h10, 3);
    rx_en = 1; m_en = 1;

    // A: single buffer frame
    set_desc(0, 'h400, 16, 1);
    send_frame(10, 3);
    check_after("A");
    chk(mem[dw(0) + 1] == 16'h0300, "R7 flags STP|ENP own clear", mem[dw(0) + 1], 16'h0300);
    chk(mem[dw(0) + 3] == 16'd10, "R7 count", mem[dw(0) + 3], 10);

    // B: chain across three descriptors, odd start address, wrap to 0
    set_desc(1, 'h501, 8, 1);
    set_desc(2, 'h600, 8, 1);
    set_desc(3, 'h700, 16, 1);
    stalls = 0;
    send_frame(20, 11);
    check_after("B");
    chk(mem[dw(1) + 1] == 16'h8200, "R6 first keeps own with STP", mem[dw(1) + 1], 16'h8200);
    chk(mem[dw(3) + 1] == 16'h0100, "R7 last ENP only", mem[dw(3) + 1], 16'h0100);
    chk(mem[dw(3) + 3] == 16'd4, "R7 last count", mem[dw(3) + 3], 4);
    chk(cur_idx == 0, "R9 wrap", cur_idx, 0);
    chk(stalls > 0, "R10 back-pressure seen", stalls, 1);

    // C: frame exactly fills buffer, next descriptor untouched
    set_desc(0, 'h420, 8, 1);
    set_desc(1, 'h520, 8, 1);
    send_frame(8, 40);
    check_after("C");
    chk(mem[dw(1) + 1] == 16'h8000, "R5 no advance on exact fill", mem[dw(1) + 1], 16'h8000);

    // D: overflow into unowned descriptor
    set_desc(1, 'h540, 4, 1);
    set_desc(2, 'h640, 4, 0);
    send_frame(10, 90);
    check_after("D");
    chk(mem[dw(1) + 1] == 16'h3200, "R8 BUFF|OFLO|STP own clear", mem[dw(1) + 1], 16'h3200);
    chk(mem[dw(1) + 3] == 16'd4, "R8 count", mem[dw(1) + 3], 4);

    // E: missed frame at unowned descriptor 2
    send_frame(5, 120);
    check_after("E");
    chk(cur_idx == 2, "R3 index unchanged", cur_idx, 2);

    // F: receive disabled, owned descriptor stays untouched
    set_desc(2, 'h660, 16, 1);
    rx_en = 0; m_en = 0;
    send_frame(6, 150);
    check_after("F");
    chk(mem[dw(2) + 1] == 16'h8000, "R2 descriptor untouched", mem[dw(2) + 1], 16'h8000);
    rx_en = 1; m_en = 1;

    // G: two-entry ring, chained frame wraps
    ring_init(8'h08, 1);
    set_desc(0, 'h440, 4, 1);
    set_desc(1, 'h460, 4, 1);
    send_frame(6, 200);
    check_after("G");
    chk(cur_idx == 0, "R9 wrap in two-entry ring", cur_idx, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + wr_chk, n_fail + wr_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + wr_chk + 1, n_fail + wr_fail + 1);
      $finish;
    end
  end
endmodule